// File: doc/BRIEF.md
# Antivalent Dual-Channel Discrepancy Monitor

This block evaluates one safety sensor whose state arrives on two separate input channels, giving a one-out-of-two evaluation. When the sensor and its wiring are healthy the two channels carry opposite levels. Channel A is the non-inverted channel, and channel B carries its complement. Each raw channel first passes through its own two-flop synchroniser. The block then produces a single registered safety output that follows channel A for as long as the pair stays antivalent.

When both channels sit at the same level, the pair is in discrepancy. A broken cable or a stuck contact looks exactly like this. A discrepancy is tolerated for a programmable number of clock cycles. During that window the output holds the last value it had while the pair was valid. If the discrepancy lasts longer than the window, the output is forced to the safe value 0 and a fault flag latches. The combining logic is AND-like: any unresolved fault drives the result inactive. The fault is cleared only when a fault-clear input is asserted while the synchronised channels are antivalent again.

Top module: `antival_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `safe_out` and `fault_latched` are both 0. The synchronisers reset to the antivalent pattern A=0, B=1.
- R2: A change on the raw channels reaches `safe_out` on the third rising clock edge after it is first sampled: two synchroniser edges and one output-register edge.
- R3: While the synchronised channels are antivalent and no fault is latched, `safe_out` equals channel A. A=1, B=0 gives 1; A=0, B=1 gives 0.
- R4: A discrepancy (A equal to B, at either level) lasting at most `disc_cycles` consecutive sampled cycles raises no fault. During it, `safe_out` keeps its value from before the discrepancy.
- R5: On the (`disc_cycles`+1)-th consecutive sampled discrepancy cycle, `fault_latched` becomes 1 and `safe_out` becomes 0 on that same edge. With `disc_cycles`=0, the first discrepancy cycle faults.
- R6: A single antivalent sampled cycle restarts the discrepancy count. Two short discrepancies, each within the limit, never fault, even when their combined length exceeds it.
- R7: Once latched, the fault and the 0 output persist through any channel activity until a valid clear occurs.
- R8: `fault_clr` asserted while the synchronised channels are equal (for example, stuck at the same level) is ignored, and the fault stays latched.
- R9: `fault_clr` high on an edge where the synchronised channels are antivalent clears the fault. On that edge `safe_out` takes channel A.
- R10: `fault_clr` asserted while no fault is latched has no effect on `safe_out` or `fault_latched`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_a_in | input | 1 | Raw non-inverted sensor channel, asynchronous |
| ch_b_in | input | 1 | Raw inverted sensor channel, asynchronous |
| disc_cycles | input | DISC_W | Tolerated discrepancy length in clock cycles |
| fault_clr | input | 1 | Fault clear request, honoured only while the pair is antivalent |
| safe_out | output | 1 | Registered safety output, 0 is the safe value |
| fault_latched | output | 1 | Registered latched discrepancy fault |

## Verification
The bench sweeps every discrepancy limit from 0 to 5 against every mismatch length from 1 to 8, for both output polarities. An off-by-one in the timer therefore shows up either as a fault one cycle too early (a fault where the length equals the limit) or one cycle too late (a missing fault where the length is one more than the limit). Sampling the output on every cycle of each tolerated mismatch catches a design that follows the glitching channels instead of holding. Separate sequences go after a counter that fails to restart between two short bursts, a clear that is honoured while the channels are stuck equal, and a latched fault that leaks away when the channels recover without a clear.

// File: rtl/av_pkg.sv
package av_pkg;
  typedef enum logic [1:0] {
    MS_TRACK = 2'd0,
    MS_HOLD  = 2'd1,
    MS_FAULT = 2'd2
  } mon_state_t;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;
endpackage

// File: rtl/av_sync.sv
module av_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= d_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/av_disc_timer.sv
module av_disc_timer #(
  parameter int unsigned DISC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mismatch,
  input  logic              run_en,
  input  logic [DISC_W-1:0] limit,
  output logic              expire
);
  localparam logic [DISC_W-1:0] CNT_MAX = {DISC_W{1'b1}};

  logic [DISC_W-1:0] elapsed_q;

  // elapsed_q counts discrepancy cycles already tolerated
  always_ff @(posedge clk) begin
    if (rst || !run_en || !mismatch) begin
      elapsed_q <= '0;
    end else if (elapsed_q != CNT_MAX) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  assign expire = run_en && mismatch && (elapsed_q >= limit);
endmodule

// File: rtl/av_out_ctrl.sv
module av_out_ctrl
  import av_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_s,
  input  logic mismatch,
  input  logic expire,
  input  logic fault_clr,
  output logic run_en,
  output logic safe_out,
  output logic fault_latched
);
  mon_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= MS_TRACK;
      safe_out      <= 1'b0;
      fault_latched <= 1'b0;
    end else begin
      unique case (state_q)
        MS_TRACK, MS_HOLD: begin
          if (expire) begin
            state_q       <= MS_FAULT;
            safe_out      <= 1'b0;
            fault_latched <= 1'b1;
          end else if (mismatch) begin
            state_q <= MS_HOLD;
          end else begin
            state_q  <= MS_TRACK;
            safe_out <= a_s;
          end
        end
        MS_FAULT: begin
          if (fault_clr && !mismatch) begin
            state_q       <= MS_TRACK;
            fault_latched <= 1'b0;
            safe_out      <= a_s;
          end else begin
            safe_out <= 1'b0;
          end
        end
        default: begin
          state_q       <= MS_FAULT;
          safe_out      <= 1'b0;
          fault_latched <= 1'b1;
        end
      endcase
    end
  end

  assign run_en = (state_q != MS_FAULT);
endmodule

// File: rtl/antival_monitor.sv
module antival_monitor
  import av_pkg::*;
#(
  parameter int unsigned DISC_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_a_in,
  input  logic              ch_b_in,
  input  logic [DISC_W-1:0] disc_cycles,
  input  logic              fault_clr,
  output logic              safe_out,
  output logic              fault_latched
);
  localparam logic [NUM_CH-1:0] SYNC_RST = 2'b10;

  logic [NUM_CH-1:0] raw_pair;
  logic [NUM_CH-1:0] sync_pair;
  logic              a_sync;
  logic              b_sync;
  logic              pair_equal;
  logic              disc_expire;
  logic              timer_run;

  assign raw_pair[CH_A] = ch_a_in;
  assign raw_pair[CH_B] = ch_b_in;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
      av_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST[ch])
      ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_pair[ch]),
        .q_out (sync_pair[ch])
      );
    end
  endgenerate

  assign a_sync     = sync_pair[CH_A];
  assign b_sync     = sync_pair[CH_B];
  assign pair_equal = (a_sync == b_sync);

  av_disc_timer #(
    .DISC_W (DISC_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .mismatch (pair_equal),
    .run_en   (timer_run),
    .limit    (disc_cycles),
    .expire   (disc_expire)
  );

  av_out_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .a_s           (a_sync),
    .mismatch      (pair_equal),
    .expire        (disc_expire),
    .fault_clr     (fault_clr),
    .run_en        (timer_run),
    .safe_out      (safe_out),
    .fault_latched (fault_latched)
  );
endmodule

// File: rtl/antival_monitor_chk.sv
module antival_monitor_chk (
  input logic clk,
  input logic rst,
  input logic a_s,
  input logic b_s,
  input logic expire,
  input logic fault_clr,
  input logic safe_out,
  input logic fault_latched
);
  assert_fault_forces_zero_R5: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> !safe_out);

  assert_fault_only_on_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    (!fault_latched && !expire) |=> !fault_latched);

  assert_track_channel_a_R3: assert property (@(posedge clk) disable iff (rst)
    (!fault_latched && (a_s != b_s)) |=> (safe_out == $past(a_s)));

  assert_hold_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    (!fault_latched && (a_s == b_s) && !expire) |=> $stable(safe_out));

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && !fault_clr) |=> fault_latched);

  assert_clear_ignored_when_equal_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && (a_s == b_s)) |=> fault_latched);

  assert_clear_when_antivalent_R9: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && fault_clr && (a_s != b_s)) |=> (!fault_latched && (safe_out == $past(a_s))));
endmodule

bind antival_monitor antival_monitor_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .a_s           (a_sync),
  .b_s           (b_sync),
  .expire        (disc_expire),
  .fault_clr     (fault_clr),
  .safe_out      (safe_out),
  .fault_latched (fault_latched)
);

// File: tb/antival_monitor_bench.sv
`timescale 1ns/1ps
module antival_monitor_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          ch_a_in;
  logic          ch_b_in;
  logic [DW-1:0] disc_cycles;
  logic          fault_clr;
  logic          safe_out;
  logic          fault_latched;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  antival_monitor #(.DISC_W(DW)) u_antival_monitor (
    .clk           (clk),
    .rst           (rst),
    .ch_a_in       (ch_a_in),
    .ch_b_in       (ch_b_in),
    .disc_cycles   (disc_cycles),
    .fault_clr     (fault_clr),
    .safe_out      (safe_out),
    .fault_latched (fault_latched)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pair(input logic a, input logic b);
    ch_a_in = a;
    ch_b_in = b;
  endtask

  task automatic restart(input logic av);
    rst = 1'b1;
    set_pair(av, ~av);
    tick(2);
    rst = 1'b0;
    tick(4);
  endtask

  initial begin
    rst = 1'b1;
    fault_clr = 1'b0;
    disc_cycles = 3;
    set_pair(1'b1, 1'b0);
    tick(2);
    chk(safe_out == 0, "R1 out in reset", safe_out, 0);
    chk(fault_latched == 0, "R1 fault in reset", fault_latched, 0);
    rst = 1'b0;
    tick(1);
    chk(safe_out == 0, "R1 out after release", safe_out, 0);
    chk(fault_latched == 0, "R1 fault after release", fault_latched, 0);
    tick(5);
    chk(safe_out == 1, "R3 a=1 b=0", safe_out, 1);

    // R2 latency: change sampled at next edge, visible on the third
    set_pair(1'b0, 1'b1);
    tick(2);
    chk(safe_out == 1, "R2 before latency", safe_out, 1);
    tick(1);
    chk(safe_out == 0, "R2 at latency", safe_out, 0);
    chk(safe_out == 0, "R3 a=0 b=1", safe_out, 0);

    // R10 clear without a fault
    set_pair(1'b1, 1'b0);
    tick(4);
    fault_clr = 1'b1;
    tick(1);
    fault_clr = 1'b0;
    chk(safe_out == 1, "R10 out unchanged", safe_out, 1);
    chk(fault_latched == 0, "R10 no fault", fault_latched, 0);

    // R5 exact expiry with limit 3
    disc_cycles = 3;
    set_pair(1'b1, 1'b1);
    tick(5);
    chk(fault_latched == 0, "R5 one before expiry", fault_latched, 0);
    chk(safe_out == 1, "R4 hold before expiry", safe_out, 1);
    tick(1);
    chk(fault_latched == 1, "R5 at expiry", fault_latched, 1);
    chk(safe_out == 0, "R5 output forced", safe_out, 0);

    // R7 channels recover, fault stays
    set_pair(1'b1, 1'b0);
    tick(4);
    chk(fault_latched == 1, "R7 fault sticky", fault_latched, 1);
    chk(safe_out == 0, "R7 out zero", safe_out, 0);
    set_pair(1'b0, 1'b1);
    tick(4);
    chk(fault_latched == 1, "R7 fault sticky 2", fault_latched, 1);

    // R8 stuck-at-equal, clear ignored
    set_pair(1'b1, 1'b1);
    tick(4);
    fault_clr = 1'b1;
    tick(1);
    fault_clr = 1'b0;
    tick(2);
    chk(fault_latched == 1, "R8 clear ignored", fault_latched, 1);
    chk(safe_out == 0, "R8 out zero", safe_out, 0);

    // R9 recovery through clear
    set_pair(1'b1, 1'b0);
    tick(4);
    fault_clr = 1'b1;
    tick(1);
    fault_clr = 1'b0;
    chk(fault_latched == 0, "R9 fault cleared", fault_latched, 0);
    chk(safe_out == 1, "R9 out follows A", safe_out, 1);

    // R6 two short bursts, total above limit
    disc_cycles = 3;
    set_pair(1'b0, 1'b0);
    tick(2);
    set_pair(1'b1, 1'b0);
    tick(1);
    set_pair(1'b0, 1'b0);
    tick(2);
    set_pair(1'b1, 1'b0);
    tick(5);
    chk(fault_latched == 0, "R6 restart on antivalent", fault_latched, 0);
    chk(safe_out == 1, "R6 out", safe_out, 1);

    // sweep limits, mismatch lengths and polarities
    for (int d = 0; d <= 5; d++) begin
      for (int len = 1; len <= 8; len++) begin
        for (int av = 0; av <= 1; av++) begin
          bit   exp_flt;
          bit   dev;
          logic lvl;
          restart(logic'(av));
          chk(safe_out == logic'(av), "R3 sweep start", safe_out, av);
          disc_cycles = DW'(d);
          lvl = logic'(len % 2);
          set_pair(lvl, lvl);
          dev = 1'b0;
          for (int i = 1; i <= len + 4; i++) begin
            tick(1);
            if (safe_out != logic'(av)) dev = 1'b1;
            if (i == len) set_pair(logic'(av), ~logic'(av));
          end
          exp_flt = (len > d);
          if (!exp_flt) chk(dev == 0, "R4 output held", dev, 0);
          chk(fault_latched == exp_flt, "R5 sweep fault", fault_latched, exp_flt);
          chk(safe_out == (exp_flt ? 1'b0 : logic'(av)), "R5 sweep out", safe_out,
              exp_flt ? 0 : av);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule